// File: doc/BRIEF.md
# Indirect-Access Lookup Table Port

This block is the register front end of a switch address table. Software never sees the entry memory directly. It sees three 32-bit data words and one table-control register. It stages an entry in the data words, then writes the control register with an index. A control write with the write flag clear copies the indexed entry into the data words, where software can read it. A control write with the flag set stores the data words into the indexed entry. Each entry is 68 bits wide. Its bits are spread over the three words in mirrored order, so the last data word holds the least significant bits.

A status register reports the table depth in units of 1024 entries; the depth is a parameter. A clear register empties the whole table in one write by marking every entry free. Software encodes the entry fields (type, VLAN id, MAC address) and the block stores them whole. Forwarding lookups and aging belong to other blocks. The bus is a plain strobe interface with no back-pressure. Every write takes effect at the clock edge where its strobe is sampled. Every read returns its data on `bus_rdata` in the cycle after its strobe, and that value holds until the next read. Software must not read and write in the same cycle.

Top module: `lookup_table_port`

## Requirements
- R1: After reset the data words and the table-control register read zero, and a load of any in-range index returns all-zero words.
- R2: A data word (byte addresses 0x0C, 0x10, 0x14 for words 0, 1, 2) reads back the full 32-bit value last written. Read data appears on `bus_rdata` in the cycle after the read strobe. The clear register (0x04) and unmapped addresses read zero.
- R3: A write to the table-control register (0x08) with bit 31 clear loads the entry selected by bits 15:0 into the data words. The load takes effect at that write's clock edge, so the very next read sees it. Word 2 receives entry bits 31:0. Word 1 receives entry bits 63:32. Word 0 bits 3:0 receive entry bits 67:64, and word 0 bits 31:4 read zero.
- R4: A table-control write with bit 31 set stores the data words into the selected entry, using the same bit mapping as R3. Word 0 bits 31:4 are discarded. The commit leaves the data words unchanged.
- R5: An index of SIZE_UNITS*1024 or more is out of range. A commit to such an index changes no entry, and this includes the entry whose low index bits it shares. A load of such an index sets all three data words to zero.
- R6: A write to the clear register with bit 0 set makes every entry free, so later loads of any index return zero words. A write with bit 0 clear has no effect.
- R7: The status register (0x00) reads SIZE_UNITS in bits 4:0 and zero above. Writes to the status register are ignored.
- R8: Entries hold every field bit for bit through commit and load: the type in bits 61:60 (0 free, 1 address, 2 VLAN, 3 VLAN plus address), the VLAN id in bits 59:48, and the MAC address in bits 47:0, with its first byte in bits 47:40.
- R9: The table-control register reads back the write flag in bit 31 and the index in bits 15:0 from its last write, with bits 30:16 reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; data follows one cycle later |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench commits an entry to an index and then commits again to that index plus 1024. A design that decodes only the low index bits would overwrite the first entry, and a later load would return the wrong words. It stages a word 0 with all high bits set. A design that keeps more than 68 bits would read back nonzero upper bits after a load. It also reads immediately after a load, which catches a load path that is one cycle late. Clear writes are issued with bit 0 both clear and set, which catches a decode that ignores the data bit. Further checks catch a word order that is not mirrored and a load of an out-of-range index that returns stale words.

// File: rtl/ltp_pkg.sv
package ltp_pkg;

  localparam int WORD_W  = 32;
  localparam int N_WORDS = 3;
  localparam int ENTRY_W = 68;
  localparam int ADDR_W  = 5;
  localparam int UNIT_ENTRIES = 1024;
  localparam int WR_FLAG_BIT  = 31;

  typedef logic [N_WORDS-1:0][WORD_W-1:0] words_t;
  typedef logic [ENTRY_W-1:0]             entry_t;

  localparam logic [ADDR_W-1:0] A_STATUS = 5'h00;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 5'h04;
  localparam logic [ADDR_W-1:0] A_CTL    = 5'h08;
  localparam logic [ADDR_W-1:0] A_WORD0  = 5'h0C;

  function automatic logic [ADDR_W-1:0] word_addr(input int n);
    return A_WORD0 + ADDR_W'(4 * n);
  endfunction

  // entry bit b lives in data word (N_WORDS-1 - b/32), bit b%32
  function automatic entry_t words_to_entry(input words_t w);
    entry_t e;
    for (int b = 0; b < ENTRY_W; b++)
      e[b] = w[N_WORDS-1 - b / WORD_W][b % WORD_W];
    return e;
  endfunction

  function automatic words_t entry_to_words(input entry_t e);
    words_t w;
    w = '0;
    for (int b = 0; b < ENTRY_W; b++)
      w[N_WORDS-1 - b / WORD_W][b % WORD_W] = e[b];
    return w;
  endfunction

endpackage

// File: rtl/ltp_entry_store.sv
module ltp_entry_store
  import ltp_pkg::*;
#(
  parameter int SIZE_UNITS  = 1,
  parameter int IDX_FIELD_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit_i,
  input  logic                   clear_i,
  input  logic [IDX_FIELD_W-1:0] idx_i,
  input  entry_t                 wr_entry_i,
  output entry_t                 rd_entry_o
);

  localparam int ENTRIES = SIZE_UNITS * UNIT_ENTRIES;
  localparam int TIDX_W  = $clog2(ENTRIES);

  entry_t             mem [ENTRIES];
  logic [ENTRIES-1:0] live;
  logic               in_range;
  logic [TIDX_W-1:0]  tidx;

  assign in_range = (32'(idx_i) < ENTRIES);
  assign tidx     = idx_i[TIDX_W-1:0];

  always_ff @(posedge clk) begin
    if (commit_i && in_range)
      mem[tidx] <= wr_entry_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      live <= '0;
    else if (clear_i)
      live <= '0;
    else if (commit_i && in_range)
      live[tidx] <= 1'b1;
  end

  always_comb begin
    rd_entry_o = '0;
    if (in_range && live[tidx])
      rd_entry_o = mem[tidx];
  end

  // R5: out-of-range commit leaves every entry state untouched
  p_oor_commit_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !in_range) |=> $stable(live));

  // R6: a clear leaves no entry in use
  p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (live == '0));

  // R4: an in-range commit makes the entry readable
  p_commit_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && in_range) |=> live[$past(tidx)]);

endmodule

// File: rtl/ltp_bus_regs.sv
module ltp_bus_regs
  import ltp_pkg::*;
#(
  parameter int SIZE_UNITS  = 1,
  parameter int IDX_FIELD_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [WORD_W-1:0]      bus_wdata,
  output logic [WORD_W-1:0]      bus_rdata,
  output logic                   commit_o,
  output logic                   clear_o,
  output logic [IDX_FIELD_W-1:0] idx_o,
  output entry_t                 wr_entry_o,
  input  entry_t                 rd_entry_i
);

  localparam int ENTRIES = SIZE_UNITS * UNIT_ENTRIES;
  localparam logic [WORD_W-1:0] STATUS_VAL = {27'b0, 5'(SIZE_UNITS)};

  words_t             words_q;
  words_t             ld_words;
  logic [N_WORDS-1:0] word_wen;
  logic [WORD_W-1:0]  ctl_q;
  logic [WORD_W-1:0]  rd_mux;
  logic               ctl_wr;
  logic               load;

  assign ctl_wr   = bus_wr && (bus_addr == A_CTL);
  assign load     = ctl_wr && !bus_wdata[WR_FLAG_BIT];
  assign commit_o = ctl_wr &&  bus_wdata[WR_FLAG_BIT];
  assign clear_o  = bus_wr && (bus_addr == A_CLEAR) && bus_wdata[0];
  assign idx_o    = bus_wdata[IDX_FIELD_W-1:0];

  assign wr_entry_o = words_to_entry(words_q);
  assign ld_words   = entry_to_words(rd_entry_i);

  for (genvar n = 0; n < N_WORDS; n++) begin : g_wen
    assign word_wen[n] = bus_wr && (bus_addr == word_addr(n));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words_q <= '0;
    end else if (load) begin
      words_q <= ld_words;
    end else begin
      for (int n = 0; n < N_WORDS; n++)
        if (word_wen[n]) words_q[n] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctl_q <= '0;
    else if (ctl_wr)
      ctl_q <= {bus_wdata[WR_FLAG_BIT], {(WORD_W-1-IDX_FIELD_W){1'b0}},
                bus_wdata[IDX_FIELD_W-1:0]};
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_STATUS) rd_mux = STATUS_VAL;
    if (bus_addr == A_CTL)    rd_mux = ctl_q;
    for (int n = 0; n < N_WORDS; n++)
      if (bus_addr == word_addr(n)) rd_mux = words_q[n];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end

  // R3: a load places the fetched entry in the data words
  p_load_copies_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (words_to_entry(words_q) == $past(rd_entry_i)));

  // R4: a commit leaves the staged words as they were
  p_commit_keeps_words_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> $stable(words_q));

  // R5: loading an index past the table returns zeros
  p_oor_load_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (32'(idx_o) >= ENTRIES)) |=> (words_q == '0));

  // R7: status always reports the configured depth
  p_status_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_STATUS) |=> (bus_rdata == STATUS_VAL));

endmodule

// File: rtl/lookup_table_port.sv
module lookup_table_port
  import ltp_pkg::*;
#(
  parameter int SIZE_UNITS  = 1,
  parameter int IDX_FIELD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata
);

  logic                   commit;
  logic                   clear;
  logic [IDX_FIELD_W-1:0] idx;
  entry_t                 wr_entry;
  entry_t                 rd_entry;

  initial begin
    assert (SIZE_UNITS >= 1 && SIZE_UNITS <= 31);
    assert (IDX_FIELD_W > $clog2(SIZE_UNITS * UNIT_ENTRIES) && IDX_FIELD_W < 31);
  end

  ltp_bus_regs #(
    .SIZE_UNITS (SIZE_UNITS),
    .IDX_FIELD_W(IDX_FIELD_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .commit_o  (commit),
    .clear_o   (clear),
    .idx_o     (idx),
    .wr_entry_o(wr_entry),
    .rd_entry_i(rd_entry)
  );

  ltp_entry_store #(
    .SIZE_UNITS (SIZE_UNITS),
    .IDX_FIELD_W(IDX_FIELD_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (commit),
    .clear_i   (clear),
    .idx_i     (idx),
    .wr_entry_i(wr_entry),
    .rd_entry_o(rd_entry)
  );

endmodule

// File: tb/tb_lookup_table_port.sv
`timescale 1ns/1ps
module tb_lookup_table_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  localparam logic [4:0] A_ST = 5'h00, A_CL = 5'h04, A_CT = 5'h08,
                         A_W0 = 5'h0C, A_W1 = 5'h10, A_W2 = 5'h14;

  always #2.5 clk = ~clk;

  lookup_table_port dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic put3(input logic [31:0] w0, w1, w2);
    wr(A_W0, w0); wr(A_W1, w1); wr(A_W2, w2);
  endtask

  task automatic chk3(input logic [31:0] w0, w1, w2, input string t);
    rd(A_W0, w0, t); rd(A_W1, w1, t); rd(A_W2, w2, t);
  endtask

  // monitor: pops the expected value for every read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd === 1'b1) begin
        @(negedge clk);
        if (exp_q.size() != 0) begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          n_cmp++;
          if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", t, bus_rdata, e);
          end
        end
      end
    end
  end

  initial begin
    #(5.0 * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk3(32'h0, 32'h0, 32'h0, "R1 words after reset");
    rd(A_CT, 32'h0, "R1 ctl after reset");
    wr(A_CT, 32'h0000_03FF);
    chk3(32'h0, 32'h0, 32'h0, "R1 load last entry after reset");

    // R7 status
    rd(A_ST, 32'h1, "R7 status depth");
    wr(A_ST, 32'hFFFF_FFFF);
    rd(A_ST, 32'h1, "R7 status after write");

    // R2 plain registers
    rd(A_CL, 32'h0, "R2 clear reads zero");
    rd(5'h18, 32'h0, "R2 unmapped reads zero");
    put3(32'hDEAD_BEEF, 32'h1234_5678, 32'hA5A5_5A5A);
    chk3(32'hDEAD_BEEF, 32'h1234_5678, 32'hA5A5_5A5A, "R2 word readback");

    // R8 address entry: type 1, vid 0x123, mac 0A1B2C3D4E5F, bits 67:64 = 9
    put3(32'hFFFF_FFF9, 32'h1123_0A1B, 32'h2C3D_4E5F);
    wr(A_CT, 32'h8000_0005);
    chk3(32'hFFFF_FFF9, 32'h1123_0A1B, 32'h2C3D_4E5F, "R4 words kept by commit");
    rd(A_CT, 32'h8000_0005, "R9 ctl readback commit");
    put3(32'h1111_1111, 32'h2222_2222, 32'h3333_3333);
    wr(A_CT, 32'h0000_0005);
    chk3(32'h0000_0009, 32'h1123_0A1B, 32'h2C3D_4E5F, "R3 R8 load entry 5");

    // R8 VLAN plus address entry at last index, all of word1 set
    put3(32'h0000_0006, 32'hFFFF_FFFF, 32'h0000_0001);
    wr(A_CT, 32'h8000_03FF);
    wr(A_CT, 32'h0000_0000);
    chk3(32'h0, 32'h0, 32'h0, "R3 load unwritten entry 0");
    wr(A_CT, 32'h0000_03FF);
    chk3(32'h0000_0006, 32'hFFFF_FFFF, 32'h0000_0001, "R8 load last entry");

    // R9 junk in bits 30:16 ignored, still a load
    put3(32'h0, 32'h0, 32'h0);
    wr(A_CT, 32'h1234_0005);
    rd(A_CT, 32'h0000_0005, "R9 ctl middle bits zero");
    chk3(32'h0000_0009, 32'h1123_0A1B, 32'h2C3D_4E5F, "R9 load with junk bits");

    // R5 out of range
    put3(32'h0000_0001, 32'h0000_0002, 32'h0000_0003);
    wr(A_CT, 32'h8000_0405);
    wr(A_CT, 32'h0000_0005);
    chk3(32'h0000_0009, 32'h1123_0A1B, 32'h2C3D_4E5F, "R5 alias commit ignored");
    wr(A_CT, 32'h0000_0405);
    chk3(32'h0, 32'h0, 32'h0, "R5 load out of range");
    put3(32'h7, 32'h7, 32'h7);
    wr(A_CT, 32'h0000_FFFF);
    chk3(32'h0, 32'h0, 32'h0, "R5 load top index");

    // R6 clear
    wr(A_CL, 32'h0000_0002);
    wr(A_CT, 32'h0000_0005);
    chk3(32'h0000_0009, 32'h1123_0A1B, 32'h2C3D_4E5F, "R6 clear bit0 low no effect");
    wr(A_CL, 32'h0000_0001);
    wr(A_CT, 32'h0000_0005);
    chk3(32'h0, 32'h0, 32'h0, "R6 entry 5 free after clear");
    wr(A_CT, 32'h0000_03FF);
    chk3(32'h0, 32'h0, 32'h0, "R6 last entry free after clear");

    // R4 commit after clear
    put3(32'h0000_000A, 32'h2FFF_0102, 32'h0304_0506);
    wr(A_CT, 32'h8000_0007);
    put3(32'h0, 32'h0, 32'h0);
    wr(A_CT, 32'h0000_0007);
    chk3(32'h0000_000A, 32'h2FFF_0102, 32'h0304_0506, "R4 commit after clear");

    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule